// File: doc/BRIEF.md
# Single-Channel Capture/Compare Timer

This block is a 16-bit up-counter behind a programmable clock divider, paired with one channel that either compares the count against a stored value or captures the count into that store. Software drives it through a small word-addressed register port: it starts and stops the count, chooses the channel direction, enables interrupt sources, clears status flags and fires one-shot events.

The divider ratio and the wrap limit are double-buffered. Writes land in preload registers, and the working copies pick them up only on an update event. An update event is either the counter wrapping past its limit or a software-forced update. The channel raises a flag on every compare hit or capture. A second flag records a capture that arrives while the first flag is still pending. A third flag records update events. The interrupt line is raised whenever any flag is set together with its own enable.

Two self-clearing event bits let software force an update (counter and divider phase cleared, working copies reloaded) or a channel event (a capture in input mode, a flag-only event in output mode).

Top module: `cap_timer`

## Requirements
- R1: After reset, the count (address 0x5), the status (address 0x3), the channel register (address 0x8), the divider preload (address 0x6) and the `irq` output all read 0.
- R2: While the run bit (address 0x0, bit 0) is 1, the count advances by one every (divider + 1) clocks. When the count is at the wrap limit, its next step sets it to 0, and this wrap is an update event that sets the update flag (status bit 2).
- R3: Writes to the divider (0x6) and wrap limit (0x7) preloads have no effect on counting until the next update event.
- R4: Writing 1 to bit 0 of the event register (0x4) clears the count and the divider phase on that clock edge. The working copies take the preload values, the update flag is set, and the divider ratio is kept.
- R5: The event register bits act only when written 1. Writing 0 to the event register changes neither the count nor the status, and the event register always reads 0.
- R6: With the direction field (0x1, bits 1:0) non-zero (input), writing 1 to event bit 1 copies the count into the channel register and sets the channel flag (status bit 0). The overcapture flag (status bit 1) is set if the channel flag was already 1.
- R7: In input mode, a rising edge on `ch_in` captures exactly like R6. A held-high level, a falling edge, or any edge in output mode captures nothing.
- R8: With the direction field at 00 (output), event bit 1 sets only the channel flag. The channel register keeps its written value and the overcapture flag stays 0.
- R9: In output mode with the counter running, the count reaching the channel register value sets the channel flag on that clock edge.
- R10: A status bit is cleared by writing 0 to it, and writing 1 to it has no effect. Reading the channel register clears the channel flag only.
- R11: `irq` is 1 exactly when some status bit and the same bit of the enable register (0x2) are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (drives read side effects) |
| addr | input | 4 | Register word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational from `addr` |
| ch_in | input | 1 | Channel capture input (rising edge) |
| irq | output | 1 | Interrupt request |

## Verification
The counter is run with a divide-by-one ratio, which shows the raw step and the wrap-to-zero with its update flag. It is also run with a divide-by-three ratio, and a forced update is issued in the middle of a divider phase. That case separates a design that clears only the count from one that also clears the phase. Captures come from both the software event and a `ch_in` edge on a stopped counter, so the expected value is exact. A second capture while the flag is pending separates the overcapture path from a plain re-capture. A held-high input, a falling edge and an edge in output mode confirm that only rising edges in input mode are taken. Output-mode events, compare hits, zero writes to the event register and write-one to status are all observed at `irq` or through reads, which shows which flag each one touches.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;

  localparam int ADDR_W = 4;
  localparam int NFLAG  = 3;

  localparam int FLG_CH  = 0;
  localparam int FLG_OVC = 1;
  localparam int FLG_UPD = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 4'h0,
    A_MODE  = 4'h1,
    A_IEN   = 4'h2,
    A_STAT  = 4'h3,
    A_EVGEN = 4'h4,
    A_CNT   = 4'h5,
    A_DIV   = 4'h6,
    A_LIMIT = 4'h7,
    A_CHREG = 4'h8
  } reg_addr_e;

  // Divider phase reaches the programmed ratio: one counter step due.
  function automatic logic phase_done(input logic [15:0] phase,
                                      input logic [15:0] ratio);
    return phase == ratio;
  endfunction

  // Next count value on a step: wrap to zero at the limit.
  function automatic logic [15:0] count_step(input logic [15:0] cur,
                                             input logic [15:0] limit);
    return (cur == limit) ? 16'd0 : cur + 16'd1;
  endfunction

  // Flag register update: a set request wins over a clear request.
  function automatic logic flag_next(input logic cur, input logic set,
                                     input logic clr);
    return set ? 1'b1 : (clr ? 1'b0 : cur);
  endfunction

endpackage

// File: rtl/cap_timer_count.sv
module cap_timer_count
  import cap_timer_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          force_upd,
  input  logic [DW-1:0] div_pre,
  input  logic [DW-1:0] lim_pre,
  output logic [DW-1:0] cnt,
  output logic          step,
  output logic          upd_evt
);

  logic [DW-1:0] phase;
  logic [DW-1:0] div_act;
  logic [DW-1:0] lim_act;
  logic          wrap;

  assign step    = run && phase_done(phase, div_act);
  assign wrap    = step && (cnt == lim_act);
  assign upd_evt = force_upd || wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      phase   <= '0;
      div_act <= '0;
      lim_act <= '0;
    end else if (force_upd) begin
      cnt     <= '0;
      phase   <= '0;
      div_act <= div_pre;
      lim_act <= lim_pre;
    end else if (run) begin
      if (step) begin
        phase <= '0;
        cnt   <= count_step(cnt, lim_act);
        if (wrap) begin
          div_act <= div_pre;
          lim_act <= lim_pre;
        end
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  AST_CNT_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= lim_act); // R2

  AST_PHASE_WITHIN_RATIO: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= div_act); // R2

  AST_FORCED_UPD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    force_upd |=> (cnt == '0) && (phase == '0)); // R4

  AST_PRELOAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_evt |=> $stable(div_act) && $stable(lim_act)); // R3

endmodule

// File: rtl/cap_timer_chan.sv
module cap_timer_chan
  import cap_timer_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_mode,
  input  logic          run,
  input  logic          force_ev,
  input  logic          ch_in,
  input  logic [DW-1:0] cnt,
  input  logic          reg_we,
  input  logic [DW-1:0] reg_wd,
  input  logic          reg_rd,
  input  logic          stat_we,
  input  logic [1:0]    stat_wd,
  output logic [DW-1:0] chreg,
  output logic          ch_flag,
  output logic          ovc_flag,
  output logic          cap_evt,
  output logic          cmp_evt
);

  logic ch_q;
  logic rise;
  logic match_now;
  logic match_q;
  logic ch_set;
  logic ch_clr;
  logic ovc_set;
  logic ovc_clr;

  assign rise      = ch_in && !ch_q;
  assign cap_evt   = in_mode && (force_ev || rise);
  assign match_now = run && !in_mode && (cnt == chreg);
  assign cmp_evt   = match_now && !match_q;

  assign ch_set  = cap_evt || cmp_evt || (force_ev && !in_mode);
  assign ch_clr  = (stat_we && !stat_wd[0]) || reg_rd;
  assign ovc_set = cap_evt && ch_flag;
  assign ovc_clr = stat_we && !stat_wd[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_q     <= 1'b0;
      match_q  <= 1'b0;
      chreg    <= '0;
      ch_flag  <= 1'b0;
      ovc_flag <= 1'b0;
    end else begin
      ch_q     <= ch_in;
      match_q  <= match_now;
      ch_flag  <= flag_next(ch_flag, ch_set, ch_clr);
      ovc_flag <= flag_next(ovc_flag, ovc_set, ovc_clr);
      if (cap_evt) begin
        chreg <= cnt;
      end else if (reg_we && !in_mode) begin
        chreg <= reg_wd;
      end
    end
  end

  AST_CAPTURE_TAKES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> chreg == $past(cnt)); // R6

  AST_OVERCAPTURE_ON_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && ch_flag) |=> ovc_flag); // R6

  AST_OUTPUT_EVENT_KEEPS_REG: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_mode && force_ev && !reg_we) |=> $stable(chreg)); // R8

  AST_EVENT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt || cmp_evt) |=> ch_flag); // R9

  AST_NO_CAPTURE_WITHOUT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_ev && !(ch_in && !ch_q) && !reg_we) |=> $stable(chreg)); // R7

endmodule

// File: rtl/cap_timer.sv
module cap_timer
  import cap_timer_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic              ch_in,
  output logic              irq
);

  logic             run;
  logic [1:0]       dir_sel;
  logic [NFLAG-1:0] ien;
  logic [DW-1:0]    div_pre;
  logic [DW-1:0]    lim_pre;
  logic             upd_flag;

  logic [DW-1:0]    cnt;
  logic             step;
  logic             upd_evt;
  logic [DW-1:0]    chreg;
  logic             ch_flag;
  logic             ovc_flag;
  logic             cap_evt;
  logic             cmp_evt;
  logic [NFLAG-1:0] flags;

  // Named bus events
  logic wr_ctrl, wr_mode, wr_ien, wr_stat, wr_ev, wr_div, wr_lim, wr_chreg;
  logic rd_chreg, force_upd, force_ev, in_mode;

  assign wr_ctrl   = wr_en && (addr == A_CTRL);
  assign wr_mode   = wr_en && (addr == A_MODE);
  assign wr_ien    = wr_en && (addr == A_IEN);
  assign wr_stat   = wr_en && (addr == A_STAT);
  assign wr_ev     = wr_en && (addr == A_EVGEN);
  assign wr_div    = wr_en && (addr == A_DIV);
  assign wr_lim    = wr_en && (addr == A_LIMIT);
  assign wr_chreg  = wr_en && (addr == A_CHREG);
  assign rd_chreg  = rd_en && (addr == A_CHREG);
  assign force_upd = wr_ev && wdata[0];
  assign force_ev  = wr_ev && wdata[1];
  assign in_mode   = (dir_sel != 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      dir_sel  <= 2'b00;
      ien      <= '0;
      div_pre  <= '0;
      lim_pre  <= '0;
      upd_flag <= 1'b0;
    end else begin
      if (wr_ctrl) run     <= wdata[0];
      if (wr_mode) dir_sel <= wdata[1:0];
      if (wr_ien)  ien     <= wdata[NFLAG-1:0];
      if (wr_div)  div_pre <= wdata;
      if (wr_lim)  lim_pre <= wdata;
      upd_flag <= flag_next(upd_flag, upd_evt, wr_stat && !wdata[FLG_UPD]);
    end
  end

  cap_timer_count #(.DW(DW)) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .force_upd (force_upd),
    .div_pre   (div_pre),
    .lim_pre   (lim_pre),
    .cnt       (cnt),
    .step      (step),
    .upd_evt   (upd_evt)
  );

  cap_timer_chan #(.DW(DW)) u_chan (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_mode  (in_mode),
    .run      (run),
    .force_ev (force_ev),
    .ch_in    (ch_in),
    .cnt      (cnt),
    .reg_we   (wr_chreg),
    .reg_wd   (wdata),
    .reg_rd   (rd_chreg),
    .stat_we  (wr_stat),
    .stat_wd  (wdata[1:0]),
    .chreg    (chreg),
    .ch_flag  (ch_flag),
    .ovc_flag (ovc_flag),
    .cap_evt  (cap_evt),
    .cmp_evt  (cmp_evt)
  );

  always_comb begin
    flags          = '0;
    flags[FLG_CH]  = ch_flag;
    flags[FLG_OVC] = ovc_flag;
    flags[FLG_UPD] = upd_flag;
  end

  assign irq = |(flags & ien);

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:  rdata[0]       = run;
      A_MODE:  rdata[1:0]     = dir_sel;
      A_IEN:   rdata[NFLAG-1:0] = ien;
      A_STAT:  rdata[NFLAG-1:0] = flags;
      A_CNT:   rdata          = cnt;
      A_DIV:   rdata          = div_pre;
      A_LIMIT: rdata          = lim_pre;
      A_CHREG: rdata          = chreg;
      default: rdata          = '0;
    endcase
  end

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ien != '0)); // R11

  AST_UPDATE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    upd_evt |=> upd_flag); // R4

  AST_ZERO_EVENT_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ev && wdata[1:0] == 2'b00 && !run) |=> $stable(cnt)); // R5

endmodule

// File: tb/test_cap_timer.sv
module test_cap_timer;
  import cap_timer_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        ch_in = 1'b0;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cap_timer i_cap_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ch_in(ch_in), .irq(irq)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  // Called at a negedge; the write is taken on the following posedge.
  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Samples rdata now (at a negedge), then lets one posedge see rd_en.
  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    addr = a; rd_en = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd(A_CNT, v);   chk("R1 count", v, 0);
    rd(A_STAT, v);  chk("R1 status", v, 0);
    rd(A_CHREG, v); chk("R1 chreg", v, 0);
    rd(A_DIV, v);   chk("R1 divider", v, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_count_wrap;
    logic [15:0] v;
    wr(A_CTRL, 0); wr(A_LIMIT, 9); wr(A_DIV, 0); wr(A_EVGEN, 1);
    wr(A_STAT, 0); wr(A_CTRL, 1);
    repeat (5) @(negedge clk);
    rd(A_CNT, v); chk("R2 count step", v, 5);
    repeat (3) @(negedge clk);
    rd(A_STAT, v); chk("R2 no update before wrap", v[2], 0);
    rd(A_STAT, v); chk("R2 update flag on wrap", v[2], 1);
    rd(A_CNT, v); chk("R2 wrapped to zero", v, 1);
  endtask

  task automatic t_preload;
    logic [15:0] a, b;
    wr(A_DIV, 4);
    rd(A_CNT, a);
    repeat (2) @(negedge clk);
    rd(A_CNT, b); chk("R3 divider preload inactive", b, (a + 3) % 10);
  endtask

  task automatic t_divider_and_update;
    logic [15:0] v;
    wr(A_CTRL, 0); wr(A_DIV, 2); wr(A_LIMIT, 100); wr(A_EVGEN, 1);
    wr(A_CTRL, 1);
    repeat (9) @(negedge clk);
    rd(A_CNT, v); chk("R2 divide by three", v, 3);
    wr(A_STAT, 0);
    wr(A_EVGEN, 1);
    rd(A_STAT, v); chk("R4 forced update flag", v[2], 1);
    @(negedge clk);
    rd(A_CNT, v); chk("R4 phase cleared", v, 0);
    repeat (2) @(negedge clk);
    rd(A_CNT, v); chk("R4 ratio kept", v, 1);
  endtask

  task automatic t_force_capture;
    logic [15:0] c, v;
    wr(A_CTRL, 0);
    rd(A_CNT, c);
    wr(A_STAT, 0); wr(A_MODE, 1);
    wr(A_EVGEN, 2);
    rd(A_STAT, v); chk("R6 capture flag", v, 3'b001);
    wr(A_EVGEN, 2);
    rd(A_STAT, v); chk("R6 overcapture", v, 3'b011);
    rd(A_CHREG, v); chk("R6 captured count", v, c);
    rd(A_STAT, v); chk("R10 read clears channel flag only", v, 3'b010);
    rd(A_EVGEN, v); chk("R5 event reg reads zero", v, 0);
  endtask

  task automatic t_edge_capture;
    logic [15:0] c, v;
    wr(A_CTRL, 1); wr(A_CTRL, 0);
    wr(A_STAT, 0);
    rd(A_CNT, c);
    ch_in = 1'b1;
    @(negedge clk);
    rd(A_STAT, v); chk("R7 edge capture flag", v, 3'b001);
    rd(A_CHREG, v); chk("R7 edge captured count", v, c);
    repeat (3) @(negedge clk);
    rd(A_STAT, v); chk("R7 held level no capture", v, 0);
    ch_in = 1'b0;
    repeat (2) @(negedge clk);
    rd(A_STAT, v); chk("R7 falling edge no capture", v, 0);
    wr(A_MODE, 0);
    ch_in = 1'b1;
    repeat (2) @(negedge clk);
    rd(A_STAT, v); chk("R7 output mode ignores edge", v, 0);
    ch_in = 1'b0;
  endtask

  task automatic t_output_event;
    logic [15:0] v;
    wr(A_CHREG, 16'h1234); wr(A_IEN, 0); wr(A_STAT, 0);
    wr(A_EVGEN, 2);
    chk("R11 flag without enable", irq, 0);
    wr(A_EVGEN, 2);
    rd(A_STAT, v); chk("R8 flag only, no overcapture", v, 3'b001);
    wr(A_IEN, 1);
    chk("R11 channel enable", irq, 1);
    wr(A_STAT, 3'b111);
    rd(A_STAT, v); chk("R10 write one no effect", v, 3'b001);
    rd(A_CHREG, v); chk("R8 register kept", v, 16'h1234);
    chk("R10 read cleared irq", irq, 0);
    wr(A_IEN, 3'b100); wr(A_EVGEN, 1);
    chk("R11 update enable", irq, 1);
    wr(A_IEN, 3'b010);
    chk("R11 mismatched enable", irq, 0);
    wr(A_STAT, 0);
    rd(A_STAT, v); chk("R10 write zero clears", v, 0);
  endtask

  task automatic t_compare;
    wr(A_CTRL, 0); wr(A_MODE, 0); wr(A_DIV, 0); wr(A_LIMIT, 50);
    wr(A_EVGEN, 1); wr(A_CHREG, 7); wr(A_IEN, 1); wr(A_STAT, 0);
    wr(A_CTRL, 1);
    repeat (7) @(negedge clk);
    chk("R9 no flag before match", irq, 0);
    @(negedge clk);
    chk("R9 flag on match", irq, 1);
  endtask

  task automatic t_zero_event;
    logic [15:0] a, v;
    wr(A_CTRL, 0); wr(A_STAT, 0);
    rd(A_CNT, a);
    wr(A_EVGEN, 0);
    rd(A_CNT, v); chk("R5 zero write keeps count", v, a);
    rd(A_STAT, v); chk("R5 zero write keeps status", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count_wrap();
    t_preload();
    t_divider_and_update();
    t_force_capture();
    t_edge_capture();
    t_output_event();
    t_compare();
    t_zero_event();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule